// File: doc/BRIEF.md
# SMBus Port Steering Register Bank

This block holds a handful of byte-wide configuration registers that sit behind a two-address I/O window. Software first writes a register number to the window's base address. The byte at the next address then reads or writes the register it named. Two of the registers form the base address and the enable of an SMBus host controller, and the block presents them as a decoded base word and an enable bit.

The same bank says which of four physical SCL/SDA pairs the single SMBus controller is wired to. In the standard layout the 2-bit port number sits in bits 2:1 of one of two registers. A control bit in a third register picks which of the two applies. In the alternate layout, chosen by a parameter, the port number sits in bits 4:3 of a separate register. In that layout only ports 0 and 1 may be used, and codes 2 and 3 connect no pair.

The multiplexer is open-drain in style. The controller gives a pull-low request for SCL and for SDA. Only the selected pair receives those requests, and every other pair stays released. The levels on the selected pair come back to the controller combinationally. Software is expected to change only the port field with a read-modify-write, and to put back the original byte once the transaction is over.

Top module: `smb_port_steer`

## Requirements
- R1: After a synchronous reset, the register index is 0x00, the base register pair holds BASE_DEFAULT with bits 4:0 cleared and the enable bit set, and the registers at indices 0x2E, 0x2F and 0x02 read 0x00. The active port is 0, and it is valid in both layouts.
- R2: A write at WINDOW_BASE loads the index. A read at WINDOW_BASE returns the index. A write at WINDOW_BASE+1 stores the byte in the register that the index names, and a read there returns that register in the same cycle.
- R3: When the index names anything other than 0x02, 0x2C, 0x2D, 0x2E or 0x2F, a data read returns 0x00 and a data write changes no register and no output.
- R4: ctrlBase equals {reg 0x2D, reg 0x2C} with bits 4:0 forced to zero. ctrlEnable equals bit 0 of reg 0x2C.
- R5: In the standard layout (ALT_LAYOUT=0), the active port is bits 2:1 of reg 0x2E when bit 0 of reg 0x2F is 1, and bits 2:1 of reg 0x2C when it is 0. All four ports are valid.
- R6: In the alternate layout (ALT_LAYOUT=1), the active port is bits 4:3 of reg 0x02. Codes 0 and 1 are valid. For codes 2 and 3, portValid is low, no pair is pulled low, and the controller sees SCL and SDA released (1).
- R7: With a valid port p, busSclLow[p] follows hostSclLow and busSdaLow[p] follows hostSdaLow, while all other pairs stay at 0. hostSclIn and hostSdaIn equal busSclIn[p] and busSdaIn[p] in the same cycle.
- R8: Reads and writes at addresses other than WINDOW_BASE and WINDOW_BASE+1 change nothing and read 0x00. ioRdData is 0x00 whenever ioRdEn is low.
- R9: A read-modify-write of reg 0x2C that changes only bits 2:1 moves the standard-layout port and leaves ctrlBase and ctrlEnable unchanged. Writing the original byte back restores the original port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ioAddr | input | ADDR_W | I/O address of the access |
| ioWrEn | input | 1 | Write strobe for one cycle |
| ioRdEn | input | 1 | Read strobe (data is combinational) |
| ioWrData | input | 8 | Write byte |
| ioRdData | output | 8 | Read byte, 0 when not selected |
| ctrlBase | output | 16 | Decoded controller base address |
| ctrlEnable | output | 1 | Controller enable |
| activePort | output | 2 | Port number currently in effect |
| portValid | output | 1 | Active port is connectable |
| hostSclLow | input | 1 | Controller pulls SCL low |
| hostSdaLow | input | 1 | Controller pulls SDA low |
| hostSclIn | output | 1 | SCL level seen by controller |
| hostSdaIn | output | 1 | SDA level seen by controller |
| busSclLow | output | 4 | Per-pair SCL pull-low |
| busSdaLow | output | 4 | Per-pair SDA pull-low |
| busSclIn | input | 4 | Per-pair SCL level |
| busSdaIn | input | 4 | Per-pair SDA level |

## Verification
Two instances, one in each layout, share the same stimulus. Every port code is reached in the standard layout, once through reg 0x2C and once through reg 0x2E, which shows that the select bit picks the right source rather than merging the two. In the alternate layout the stimulus steps through codes that land on valid and on reserved ports, which separates true disconnection from aliasing onto another pair. At each selection the bus input levels and the pull-low requests are swept over patterns that differ per pair, so a pair routed to the wrong place shows up as a wrong level.

// File: rtl/smbsteer_pkg.sv
package smbsteer_pkg;
  localparam int NUM_PORTS = 4;
  localparam int PORT_W = $clog2(NUM_PORTS);
  localparam int NUM_REGS = 5;
  localparam int ALT_MAIN_PORTS = 2;

  localparam logic [7:0] IDX_BASE_LO = 8'h2C;
  localparam logic [7:0] IDX_BASE_HI = 8'h2D;
  localparam logic [7:0] IDX_SEL_B   = 8'h2E;
  localparam logic [7:0] IDX_SEL_CTL = 8'h2F;
  localparam logic [7:0] IDX_ALT_FLD = 8'h02;

  typedef struct packed {
    logic idxWr;
    logic idxRd;
    logic datWr;
    logic datRd;
  } winStrobe_t;

  function automatic logic [7:0] regIndex(int k);
    case (k)
      0: return IDX_BASE_LO;
      1: return IDX_BASE_HI;
      2: return IDX_SEL_B;
      3: return IDX_SEL_CTL;
      default: return IDX_ALT_FLD;
    endcase
  endfunction
endpackage

// File: rtl/smbsteer_ctrl.sv
module smbsteer_ctrl
  import smbsteer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WINDOW_BASE = 16'h0C50
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  output winStrobe_t        stb
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = WINDOW_BASE + 1'b1;

  logic hitIdx;
  logic hitDat;

  assign hitIdx = (ioAddr == WINDOW_BASE);
  assign hitDat = (ioAddr == DATA_ADDR);

  always_comb begin
    stb.idxWr = ioWrEn & hitIdx;
    stb.idxRd = ioRdEn & hitIdx;
    stb.datWr = ioWrEn & hitDat;
    stb.datRd = ioRdEn & hitDat;
  end
endmodule

// File: rtl/smbsteer_regs.sv
module smbsteer_regs
  import smbsteer_pkg::*;
#(
  parameter bit ALT_LAYOUT = 1'b0,
  parameter logic [15:0] BASE_DEFAULT = 16'h0B20
) (
  input  logic              clk,
  input  logic              rst,
  input  winStrobe_t        stb,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic [15:0]       ctrlBase,
  output logic              ctrlEnable,
  output logic [PORT_W-1:0] activePort,
  output logic              portValid
);
  logic [7:0] curIdx;
  logic [NUM_REGS-1:0][7:0] regVal;
  logic idxImpl;
  logic [7:0] selVal;

  function automatic logic [7:0] defaultFor(int k);
    case (k)
      0: return {BASE_DEFAULT[7:5], 4'b0000, 1'b1};
      1: return BASE_DEFAULT[15:8];
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      curIdx <= 8'h00;
    end else if (stb.idxWr) begin
      curIdx <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rst) begin
        regVal[k] <= defaultFor(k);
      end else if (stb.datWr && (curIdx == regIndex(k))) begin
        regVal[k] <= wrData;
      end
    end
  end

  always_comb begin
    idxImpl = 1'b0;
    selVal  = 8'h00;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (curIdx == regIndex(k)) begin
        idxImpl = 1'b1;
        selVal  = regVal[k];
      end
    end
  end

  always_comb begin
    if (stb.idxRd) begin
      rdData = curIdx;
    end else if (stb.datRd && idxImpl) begin
      rdData = selVal;
    end else begin
      rdData = 8'h00;
    end
  end

  assign ctrlBase   = {regVal[1], regVal[0][7:5], 5'b00000};
  assign ctrlEnable = regVal[0][0];

  generate
    if (ALT_LAYOUT) begin : g_altField
      assign activePort = regVal[4][4:3];
      assign portValid  = (int'(activePort) < ALT_MAIN_PORTS);
    end else begin : g_stdField
      assign activePort = regVal[3][0] ? regVal[2][2:1] : regVal[0][2:1];
      assign portValid  = 1'b1;
    end
  endgenerate

  // R2: a data write to an implemented register is read back next cycle
  assert_data_write_R2: assert property (@(posedge clk) disable iff (rst)
    (stb.datWr && idxImpl) |=> (selVal == $past(wrData)));

  // R3: a data write to an unimplemented index changes no output
  assert_unimpl_write_R3: assert property (@(posedge clk) disable iff (rst)
    (stb.datWr && !idxImpl) |=> ($stable(ctrlBase) && $stable(ctrlEnable)
                                 && $stable(activePort) && $stable(portValid)));
endmodule

// File: rtl/smbsteer_portmux.sv
module smbsteer_portmux
  import smbsteer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PORT_W-1:0]    activePort,
  input  logic                 portValid,
  input  logic                 hostSclLow,
  input  logic                 hostSdaLow,
  output logic                 hostSclIn,
  output logic                 hostSdaIn,
  output logic [NUM_PORTS-1:0] busSclLow,
  output logic [NUM_PORTS-1:0] busSdaLow,
  input  logic [NUM_PORTS-1:0] busSclIn,
  input  logic [NUM_PORTS-1:0] busSdaIn
);
  logic [NUM_PORTS-1:0] pairSel;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pair
      assign pairSel[p]   = portValid && (activePort == PORT_W'(p));
      assign busSclLow[p] = pairSel[p] & hostSclLow;
      assign busSdaLow[p] = pairSel[p] & hostSdaLow;
    end
  endgenerate

  assign hostSclIn = portValid ? busSclIn[activePort] : 1'b1;
  assign hostSdaIn = portValid ? busSdaIn[activePort] : 1'b1;

  assert_onehot_scl_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busSclLow));
  assert_onehot_sda_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busSdaLow));
  assert_host_reach_R7: assert property (@(posedge clk) disable iff (rst)
    (portValid && hostSclLow) |-> ($countones(busSclLow) == 1));
  assert_reserved_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !portValid |-> (busSclLow == '0 && busSdaLow == '0 && hostSclIn && hostSdaIn));
endmodule

// File: rtl/smb_port_steer.sv
module smb_port_steer
  import smbsteer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WINDOW_BASE = 16'h0C50,
  parameter logic [15:0] BASE_DEFAULT = 16'h0B20,
  parameter bit ALT_LAYOUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  output logic [15:0]       ctrlBase,
  output logic              ctrlEnable,
  output logic [1:0]        activePort,
  output logic              portValid,
  input  logic              hostSclLow,
  input  logic              hostSdaLow,
  output logic              hostSclIn,
  output logic              hostSdaIn,
  output logic [3:0]        busSclLow,
  output logic [3:0]        busSdaLow,
  input  logic [3:0]        busSclIn,
  input  logic [3:0]        busSdaIn
);
  winStrobe_t stb;

  smbsteer_ctrl #(.ADDR_W(ADDR_W), .WINDOW_BASE(WINDOW_BASE)) u_ctrl (
    .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .stb(stb)
  );

  smbsteer_regs #(.ALT_LAYOUT(ALT_LAYOUT), .BASE_DEFAULT(BASE_DEFAULT)) u_regs (
    .clk(clk), .rst(rst), .stb(stb), .wrData(ioWrData), .rdData(ioRdData),
    .ctrlBase(ctrlBase), .ctrlEnable(ctrlEnable),
    .activePort(activePort), .portValid(portValid)
  );

  smbsteer_portmux u_mux (
    .clk(clk), .rst(rst), .activePort(activePort), .portValid(portValid),
    .hostSclLow(hostSclLow), .hostSdaLow(hostSdaLow),
    .hostSclIn(hostSclIn), .hostSdaIn(hostSdaIn),
    .busSclLow(busSclLow), .busSdaLow(busSdaLow),
    .busSclIn(busSclIn), .busSdaIn(busSdaIn)
  );
endmodule

// File: tb/smb_port_steer_tb.sv
module smb_port_steer_tb;
  localparam logic [15:0] WB = 16'h0C50;
  localparam logic [15:0] BD = 16'h0B20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] ioAddr = 16'h0000;
  logic ioWrEn = 1'b0, ioRdEn = 1'b0;
  logic [7:0] ioWrData = 8'h00;
  logic hostSclLow = 1'b0, hostSdaLow = 1'b0;
  logic [3:0] busSclIn = 4'hF, busSdaIn = 4'hF;

  logic [7:0] rdS, rdA;
  logic [15:0] baseS, baseA;
  logic enS, enA, valS, valA, sclInS, sdaInS, sclInA, sdaInA;
  logic [1:0] portS, portA;
  logic [3:0] sclLowS, sdaLowS, sclLowA, sdaLowA;

  int nChecks = 0, nFail = 0;
  bit done = 0, seenRst = 0;
  logic [7:0] mReg [256];
  int mIdx = 0;

  always #4 clk = ~clk;

  smb_port_steer #(.WINDOW_BASE(WB), .BASE_DEFAULT(BD), .ALT_LAYOUT(1'b0)) u_dut (
    .clk(clk), .rst(rst), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioWrData(ioWrData), .ioRdData(rdS), .ctrlBase(baseS), .ctrlEnable(enS),
    .activePort(portS), .portValid(valS), .hostSclLow(hostSclLow),
    .hostSdaLow(hostSdaLow), .hostSclIn(sclInS), .hostSdaIn(sdaInS),
    .busSclLow(sclLowS), .busSdaLow(sdaLowS), .busSclIn(busSclIn), .busSdaIn(busSdaIn));

  smb_port_steer #(.WINDOW_BASE(WB), .BASE_DEFAULT(BD), .ALT_LAYOUT(1'b1)) u_dutAlt (
    .clk(clk), .rst(rst), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioWrData(ioWrData), .ioRdData(rdA), .ctrlBase(baseA), .ctrlEnable(enA),
    .activePort(portA), .portValid(valA), .hostSclLow(hostSclLow),
    .hostSdaLow(hostSdaLow), .hostSclIn(sclInA), .hostSdaIn(sdaInA),
    .busSclLow(sclLowA), .busSdaLow(sdaLowA), .busSclIn(busSclIn), .busSdaIn(busSdaIn));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit isImpl(int i);
    return (i == 8'h02) || (i >= 8'h2C && i <= 8'h2F);
  endfunction

  function automatic logic [1:0] expStdPort();
    return mReg[8'h2F][0] ? mReg[8'h2E][2:1] : mReg[8'h2C][2:1];
  endfunction

  function automatic logic [7:0] expRd();
    if (!ioRdEn) return 8'h00;
    if (ioAddr == WB) return 8'(mIdx);
    if (ioAddr == WB + 16'd1) return isImpl(mIdx) ? mReg[mIdx] : 8'h00;
    return 8'h00;
  endfunction

  function automatic logic [3:0] expLow(input logic [1:0] p, input bit v, input logic req);
    logic [3:0] r = 4'h0;
    if (v && req) r[p] = 1'b1;
    return r;
  endfunction

  // reference model, updated each rising edge, compared 3 ns later
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mReg[i] = 8'h00;
      mReg[8'h2C] = {BD[7:5], 5'b00001};
      mReg[8'h2D] = BD[15:8];
      mIdx = 0;
      seenRst = 1;
    end else begin
      if (ioWrEn && ioAddr == WB) mIdx = int'(ioWrData);
      else if (ioWrEn && ioAddr == WB + 16'd1 && isImpl(mIdx)) mReg[mIdx] = ioWrData;
    end
    #3;
    if (seenRst && !done) begin
      logic [1:0] sp, ap;
      bit av;
      logic [15:0] eb;
      sp = expStdPort();
      ap = mReg[8'h02][4:3];
      av = (ap < 2);
      eb = {mReg[8'h2D], mReg[8'h2C][7:5], 5'b0};
      chk(rdS == expRd() && rdA == expRd(), "R2 read data", {rdS, rdA}, {expRd(), expRd()});
      chk(baseS == eb && baseA == eb && enS == mReg[8'h2C][0] && enA == mReg[8'h2C][0],
          "R4 base/enable", {baseS, 7'b0, enS}, {eb, 7'b0, mReg[8'h2C][0]});
      chk(portS == sp && valS, "R5 std port", {valS, portS}, {1'b1, sp});
      chk(portA == ap && valA == av, "R6 alt port", {valA, portA}, {av, ap});
      chk(sclLowS == expLow(sp, 1, hostSclLow) && sdaLowS == expLow(sp, 1, hostSdaLow)
          && sclInS == busSclIn[sp] && sdaInS == busSdaIn[sp],
          "R7 std mux", {sclLowS, sdaLowS, 2'b0, sclInS, sdaInS}, {expLow(sp, 1, hostSclLow), expLow(sp, 1, hostSdaLow), 2'b0, busSclIn[sp], busSdaIn[sp]});
      chk(sclLowA == expLow(ap, av, hostSclLow) && sdaLowA == expLow(ap, av, hostSdaLow)
          && sclInA == (av ? busSclIn[ap] : 1'b1) && sdaInA == (av ? busSdaIn[ap] : 1'b1),
          "R6 R7 alt mux", {sclLowA, sdaLowA, 2'b0, sclInA, sdaInA}, {expLow(ap, av, hostSclLow), expLow(ap, av, hostSdaLow)});
    end
  end

  task automatic wrIdx(input logic [7:0] v);
    @(negedge clk); ioAddr = WB; ioWrEn = 1'b1; ioWrData = v;
    @(negedge clk); ioWrEn = 1'b0;
  endtask

  task automatic wrReg(input logic [7:0] idx, input logic [7:0] v);
    wrIdx(idx);
    ioAddr = WB + 16'd1; ioWrEn = 1'b1; ioWrData = v;
    @(negedge clk); ioWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] idx, output logic [7:0] v);
    wrIdx(idx);
    ioAddr = WB + 16'd1; ioRdEn = 1'b1;
    #1; v = rdS;
    @(negedge clk); ioRdEn = 1'b0;
  endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] v, orig;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(baseS == 16'h0B20 && enS, "R1 base/enable", {baseS, 7'b0, enS}, {16'h0B20, 8'h01});
    chk(portS == 2'd0 && valS && portA == 2'd0 && valA, "R1 port", {valS, portS, valA, portA}, 6'b100100);
    rdReg(8'h2E, v); chk(v == 8'h00, "R1 reg 2E", v, 8'h00);
    rdReg(8'h2C, v); chk(v == 8'h21, "R1 reg 2C", v, 8'h21);

    // R2 / R4 / R5
    wrReg(8'h2D, 8'h3C); wrReg(8'h2C, 8'hA7);
    chk(baseS == 16'h3CA0 && enS, "R4 base", baseS, 16'h3CA0);
    chk(portS == 2'd3, "R5 from 2C", portS, 2'd3);
    rdReg(8'h2D, v); chk(v == 8'h3C, "R2 readback", v, 8'h3C);
    wrReg(8'h2C, 8'hA6);
    chk(!enS && baseS == 16'h3CA0, "R4 enable off", {baseS, 7'b0, enS}, {16'h3CA0, 8'h00});
    wrReg(8'h2E, 8'h02); wrReg(8'h2F, 8'h01);
    chk(portS == 2'd1, "R5 from 2E", portS, 2'd1);

    // R7 mux sweep over all standard-layout ports
    for (int p = 0; p < 4; p++) begin
      wrReg(8'h2E, 8'(p << 1));
      for (int pat = 0; pat < 16; pat++) begin
        @(negedge clk);
        busSclIn = 4'(pat); busSdaIn = ~4'(pat);
        hostSclLow = pat[0]; hostSdaLow = pat[1];
        #1;
        chk(sclInS == busSclIn[p] && sdaInS == busSdaIn[p], "R7 host levels",
            {sclInS, sdaInS}, {busSclIn[p], busSdaIn[p]});
        chk(sclLowS == (pat[0] ? 4'(1 << p) : 4'h0), "R7 pull-low route", sclLowS, pat[0] ? 4'(1 << p) : 4'h0);
      end
    end
    wrReg(8'h2F, 8'h00);
    chk(portS == 2'd3, "R5 back to 2C", portS, 2'd3);

    // R6 alternate layout with reserved codes
    @(negedge clk); hostSclLow = 1'b1; hostSdaLow = 1'b1; busSclIn = 4'h0; busSdaIn = 4'h0;
    wrReg(8'h02, 8'h10);
    chk(!valA && sclLowA == 4'h0 && sclInA && sdaInA, "R6 reserved 2",
        {valA, sclLowA, sclInA, sdaInA}, 7'b0000011);
    wrReg(8'h02, 8'h18);
    chk(!valA && sdaLowA == 4'h0 && portA == 2'd3, "R6 reserved 3", {valA, portA}, 3'b011);
    wrReg(8'h02, 8'h08);
    chk(valA && portA == 2'd1 && sclLowA == 4'b0010 && !sclInA, "R6 valid 1",
        {valA, portA, sclLowA}, 7'b1010010);
    wrReg(8'h02, 8'h00);
    chk(valA && portA == 2'd0, "R6 valid 0", {valA, portA}, 3'b100);

    // R3 unimplemented indices
    wrReg(8'h40, 8'h55);
    rdReg(8'h40, v); chk(v == 8'h00, "R3 read 40", v, 8'h00);
    wrReg(8'hFF, 8'hFF);
    rdReg(8'hFF, v); chk(v == 8'h00, "R3 read FF", v, 8'h00);
    chk(baseS == 16'h3CA0 && portS == 2'd3 && !enS, "R3 outputs kept", {baseS, portS}, {16'h3CA0, 2'd3});

    // R8 accesses outside the window
    @(negedge clk); ioAddr = WB + 16'd2; ioWrEn = 1'b1; ioWrData = 8'h2C;
    @(negedge clk); ioAddr = WB - 16'd1;
    @(negedge clk); ioWrEn = 1'b0; ioAddr = WB + 16'd2; ioRdEn = 1'b1;
    #1; chk(rdS == 8'h00, "R8 outside read", rdS, 8'h00);
    @(negedge clk); ioAddr = WB;
    #1; chk(rdS == 8'hFF, "R8 index kept", rdS, 8'hFF);
    @(negedge clk); ioRdEn = 1'b0;
    #1; chk(rdS == 8'h00, "R8 idle read", rdS, 8'h00);

    // R9 read-modify-write and restore of the port field
    wrReg(8'h2C, 8'hA7);
    rdReg(8'h2C, orig);
    wrReg(8'h2C, (orig & 8'hF9) | 8'h04);
    chk(portS == 2'd2 && baseS == 16'h3CA0 && enS, "R9 field moved", {baseS, portS}, {16'h3CA0, 2'd2});
    wrReg(8'h2C, orig);
    rdReg(8'h2C, v);
    chk(v == orig && portS == 2'd3, "R9 restored", {v, portS}, {orig, 2'd3});

    repeat (3) @(negedge clk);
    summary();
  end
endmodule